// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that finishes each instruction in the same clock edge that fetches it. It runs five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than), plus a word load, a word store and a branch taken when two registers are equal. Instruction fetch and data access happen in the same cycle, so the core has its own instruction array and its own data array. It also holds a 32-entry register file, an ALU with a zero flag, a 16-to-32 sign extender and next-PC logic.

While reset is held, a program port writes words into either array. A combinational debug port reads back any instruction word, data word or register at any time. A decoder turns the opcode and function fields into a small set of strobes. These strobes choose the destination register, the second ALU operand, the write-back source and the next PC.

Top module: `onecycle_cpu`

## Requirements
- R1: A synchronous reset sets the PC to 0 and clears all registers. No instruction runs while reset is high, and the program port may write either array during reset.
- R2: Every instruction takes one clock cycle. Unless a branch is taken, the PC rises by 4 on each edge after reset is released. Instruction word i sits at byte address 4*i.
- R3: With opcode bits [31:26] = 0, the register format applies: rs in [25:21], rt in [20:16], rd in [15:11], shamt in [10:6], funct in [5:0]. The core writes R[rd] = R[rs] op R[rt], where funct 32 is add, 34 is subtract, 36 is and, and 37 is or.
- R4: Funct 42 writes 1 to R[rd] when R[rs] is less than R[rt] as signed numbers, and writes 0 otherwise.
- R5: Opcode 35 (load) writes R[rt] with the data word at R[rs] + sign-extended imm[15:0]. The word index is address bits [N+1:2]. Negative offsets work.
- R6: Opcode 43 (store) writes R[rt] to the data word at R[rs] + sign-extended imm[15:0]. It writes no register.
- R7: Opcode 4 (branch if equal) compares R[rs] and R[rt]. If they are equal, the next PC is PC + 4 + (sign-extended imm shifted left by 2), which can point backward. If they differ, the next PC is PC + 4.
- R8: Register 0 always reads as 0, and writes to it are ignored.
- R9: Any other opcode, or a register-format word with an unknown funct or a nonzero shamt, is a no-op. It only advances the PC.
- R10: The debug port reads combinationally. Select 0 reads an instruction word, 1 reads a data word and 2 reads a register. The program port writes the instruction array when its select is 0 and the data array when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| progWe | input | 1 | Program-port write strobe |
| progSel | input | 1 | Program target: 0 instruction array, 1 data array |
| progAddr | input | ADDR_W | Program word index |
| progData | input | 32 | Program write data |
| dbgSel | input | 2 | Debug source: 0 instruction, 1 data, 2 register |
| dbgAddr | input | ADDR_W | Debug word or register index |
| dbgData | output | 32 | Debug read data |
| pc | output | 32 | Current program counter (byte address) |

## Verification
A preloaded program uses operand pairs of opposite sign. An add, subtract, and, or and both slt directions then give results that no other operation or an unsigned compare would give. Loads use both positive and negative offsets. A store lands over a marker word, and a store of r0 shows that the write to r0 was dropped. A branch that is not taken is followed by a taken forward branch over two writers and then a self-loop branch. The final PC and the untouched registers tell apart a fall-through, a skip and a backward target. An undefined opcode aimed at a fresh register shows that it is a no-op. Reset is checked both before the program runs and in the middle of a run.

// File: rtl/onecycle_pkg.sv
package onecycle_pkg;

  localparam logic [5:0] OP_RFMT  = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } aluOp_e;

  typedef struct packed {
    logic   regDst;    // 1: write rd, 0: write rt
    logic   aluSrc;    // 1: immediate, 0: register
    logic   memToReg;  // 1: memory data, 0: ALU result
    logic   regWrite;
    logic   memWrite;
    logic   branch;
    aluOp_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/onecycle_alu.sv
module onecycle_alu
  import onecycle_pkg::*;
(
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  aluOp_e      aluOp,
  output logic [31:0] result,
  output logic        zero
);

  always_comb begin
    unique case (aluOp)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = {31'd0, $signed(opA) < $signed(opB)};
      default: result = 32'd0;
    endcase
  end

  assign zero = (result == 32'd0);

endmodule

// File: rtl/onecycle_regfile.sv
module onecycle_regfile #(
  parameter int NREGS = 32,
  localparam int RAW = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RAW-1:0] addrA,
  input  logic [RAW-1:0] addrB,
  input  logic [RAW-1:0] addrDbg,
  output logic [31:0]    dataA,
  output logic [31:0]    dataB,
  output logic [31:0]    dataDbg,
  input  logic           wrEn,
  input  logic [RAW-1:0] wrAddr,
  input  logic [31:0]    wrData
);

  logic [31:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= 32'd0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign dataA   = (addrA   == '0) ? 32'd0 : regs[addrA];
  assign dataB   = (addrB   == '0) ? 32'd0 : regs[addrB];
  assign dataDbg = (addrDbg == '0) ? 32'd0 : regs[addrDbg];

endmodule

// File: rtl/onecycle_control.sv
module onecycle_control
  import onecycle_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{regDst: 1'b0, aluSrc: 1'b0, memToReg: 1'b0, regWrite: 1'b0,
             memWrite: 1'b0, branch: 1'b0, aluOp: ALU_ADD};
    unique case (opcode)
      OP_RFMT: begin
        ctrl.regDst = 1'b1;
        if (shamt == 5'd0) begin
          ctrl.regWrite = 1'b1;
          unique case (funct)
            FN_ADD:  ctrl.aluOp = ALU_ADD;
            FN_SUB:  ctrl.aluOp = ALU_SUB;
            FN_AND:  ctrl.aluOp = ALU_AND;
            FN_OR:   ctrl.aluOp = ALU_OR;
            FN_SLT:  ctrl.aluOp = ALU_SLT;
            default: ctrl.regWrite = 1'b0;
          endcase
        end
      end
      OP_LOAD: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.regWrite = 1'b1;
      end
      OP_STORE: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/onecycle_datapath.sv
module onecycle_datapath
  import onecycle_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int ADDR_W     = 6,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  output logic [31:0]       instr,
  input  logic              progWe,
  input  logic              progSel,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [31:0]       progData,
  input  logic [1:0]        dbgSel,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [31:0]       dbgData,
  output logic [31:0]       pcOut
);

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] pcQ, pcPlus4, brOff, pcNext;
  logic [4:0]  rsF, rtF, rdF, wrAddr;
  logic [31:0] regA, regB, regDbg, sext, aluB, aluRes, memRd, wbData;
  logic        aluZero;
  logic [DAW-1:0] dIdx;

  // fetch
  assign instr = imem[pcQ[IAW+1:2]];
  assign rsF   = instr[25:21];
  assign rtF   = instr[20:16];
  assign rdF   = instr[15:11];
  assign sext  = {{16{instr[15]}}, instr[15:0]};

  onecycle_regfile #(.NREGS(32)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .addrA  (rsF),
    .addrB  (rtF),
    .addrDbg(dbgAddr[4:0]),
    .dataA  (regA),
    .dataB  (regB),
    .dataDbg(regDbg),
    .wrEn   (ctrl.regWrite && !rst),
    .wrAddr (wrAddr),
    .wrData (wbData)
  );

  assign aluB = ctrl.aluSrc ? sext : regB;

  onecycle_alu u_alu (
    .opA   (regA),
    .opB   (aluB),
    .aluOp (ctrl.aluOp),
    .result(aluRes),
    .zero  (aluZero)
  );

  // data access and write-back
  assign dIdx   = aluRes[DAW+1:2];
  assign memRd  = dmem[dIdx];
  assign wbData = ctrl.memToReg ? memRd : aluRes;
  assign wrAddr = ctrl.regDst ? rdF : rtF;

  always_ff @(posedge clk) begin
    if (progWe && progSel) dmem[progAddr[DAW-1:0]] <= progData;
    else if (!rst && ctrl.memWrite) dmem[dIdx] <= regB;
  end

  always_ff @(posedge clk) begin
    if (progWe && !progSel) imem[progAddr[IAW-1:0]] <= progData;
  end

  // next PC
  assign pcPlus4 = pcQ + 32'd4;
  assign brOff   = {sext[29:0], 2'b00};
  assign pcNext  = (ctrl.branch && aluZero) ? (pcPlus4 + brOff) : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pcQ <= 32'd0;
    else     pcQ <= pcNext;
  end

  assign pcOut = pcQ;

  always_comb begin
    unique case (dbgSel)
      2'd0:    dbgData = imem[dbgAddr[IAW-1:0]];
      2'd1:    dbgData = dmem[dbgAddr[DAW-1:0]];
      2'd2:    dbgData = regDbg;
      default: dbgData = 32'd0;
    endcase
  end

  // ---------------- assertions ----------------
  logic knownOp;
  assign knownOp = (instr[31:26] == OP_RFMT) || (instr[31:26] == OP_LOAD) ||
                   (instr[31:26] == OP_STORE) || (instr[31:26] == OP_BEQ);

  p_held_reset_r1: assert property (@(posedge clk) rst |=> pcQ == 32'd0);

  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.branch && aluZero) |=> pcQ == $past(pcQ) + 32'd4);

  p_slt_bool_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.aluOp == ALU_SLT) |-> aluRes[31:1] == 31'd0);

  p_store_lands_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.memWrite && !progWe) |=> dmem[$past(dIdx)] == $past(regB));

  p_branch_target_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && regA == regB) |=> pcQ == $past(pcQ) + 32'd4 + $past(brOff));

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (rsF == 5'd0) |-> regA == 32'd0);

  p_undef_nop_r9: assert property (@(posedge clk) disable iff (rst)
    !knownOp |-> !ctrl.regWrite && !ctrl.memWrite && !ctrl.branch);

endmodule

// File: rtl/onecycle_cpu.sv
module onecycle_cpu
  import onecycle_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW    = $clog2(IMEM_WORDS),
  localparam int DAW    = $clog2(DMEM_WORDS),
  localparam int MAXMEM = (IAW > DAW) ? IAW : DAW,
  localparam int ADDR_W = (MAXMEM > 5) ? MAXMEM : 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              progWe,
  input  logic              progSel,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [31:0]       progData,
  input  logic [1:0]        dbgSel,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [31:0]       dbgData,
  output logic [31:0]       pc
);

  ctrl_t       ctrl;
  logic [31:0] instr;

  onecycle_control u_ctrl (
    .opcode(instr[31:26]),
    .shamt (instr[10:6]),
    .funct (instr[5:0]),
    .ctrl  (ctrl)
  );

  onecycle_datapath #(
    .IMEM_WORDS(IMEM_WORDS),
    .DMEM_WORDS(DMEM_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .instr   (instr),
    .progWe  (progWe),
    .progSel (progSel),
    .progAddr(progAddr),
    .progData(progData),
    .dbgSel  (dbgSel),
    .dbgAddr (dbgAddr),
    .dbgData (dbgData),
    .pcOut   (pc)
  );

endmodule

// File: tb/test_onecycle_cpu.sv
module test_onecycle_cpu;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          progWe = 1'b0;
  logic          progSel = 1'b0;
  logic [AW-1:0] progAddr = '0;
  logic [31:0]   progData = '0;
  logic [1:0]    dbgSel = '0;
  logic [AW-1:0] dbgAddr = '0;
  logic [31:0]   dbgData, pc;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  onecycle_cpu i_onecycle_cpu (
    .clk(clk), .rst(rst), .progWe(progWe), .progSel(progSel),
    .progAddr(progAddr), .progData(progData), .dbgSel(dbgSel),
    .dbgAddr(dbgAddr), .dbgData(dbgData), .pc(pc)
  );

  // program: {op,rs,rt,rd,shamt,funct} or {op,rs,rt,imm}
  localparam int NPROG = 20;
  localparam logic [31:0] PROG [NPROG] = '{
    {6'd35, 5'd0, 5'd1, 16'd0},               // 0  lw  r1,0(r0)
    {6'd35, 5'd0, 5'd2, 16'd4},               // 1  lw  r2,4(r0)
    {6'd35, 5'd0, 5'd6, 16'd8},               // 2  lw  r6,8(r0)
    {6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'd32},    // 3  add r3,r1,r2
    {6'd0, 5'd1, 5'd2, 5'd4, 5'd0, 6'd34},    // 4  sub r4,r1,r2
    {6'd0, 5'd1, 5'd6, 5'd5, 5'd0, 6'd36},    // 5  and r5,r1,r6
    {6'd0, 5'd1, 5'd6, 5'd7, 5'd0, 6'd37},    // 6  or  r7,r1,r6
    {6'd0, 5'd2, 5'd1, 5'd8, 5'd0, 6'd42},    // 7  slt r8,r2,r1
    {6'd0, 5'd1, 5'd2, 5'd9, 5'd0, 6'd42},    // 8  slt r9,r1,r2
    {6'd43, 5'd0, 5'd3, 16'd12},              // 9  sw  r3,12(r0)
    {6'd0, 5'd1, 5'd1, 5'd0, 5'd0, 6'd32},    // 10 add r0,r1,r1
    {6'd43, 5'd0, 5'd0, 16'd16},              // 11 sw  r0,16(r0)
    {6'd4, 5'd1, 5'd2, 16'd5},                // 12 beq r1,r2,+5 (not taken)
    {6'd4, 5'd1, 5'd1, 16'd2},                // 13 beq r1,r1,+2 (taken -> 16)
    {6'd0, 5'd1, 5'd1, 5'd10, 5'd0, 6'd32},   // 14 skipped
    {6'd0, 5'd1, 5'd1, 5'd10, 5'd0, 6'd32},   // 15 skipped
    {6'd63, 5'd1, 5'd11, 16'h0820},           // 16 undefined opcode
    {6'd35, 5'd4, 5'd12, 16'hFFFC},           // 17 lw  r12,-4(r4)
    {6'd43, 5'd4, 5'd7, 16'd12},              // 18 sw  r7,12(r4)
    {6'd4, 5'd0, 5'd0, 16'hFFFF}              // 19 beq r0,r0,-1 (self loop)
  };

  // expected vectors: {requirement, dbgSel, index, value}
  localparam int NVEC = 19;
  localparam logic [47:0] VEC [NVEC] = '{
    {8'd5,  2'd2, 6'd1,  32'd5},          // R5 load +0
    {8'd5,  2'd2, 6'd2,  32'hFFFFFFFD},   // R5 load +4
    {8'd5,  2'd2, 6'd6,  32'd12},         // R5
    {8'd3,  2'd2, 6'd3,  32'd2},          // R3 add
    {8'd3,  2'd2, 6'd4,  32'd8},          // R3 sub
    {8'd3,  2'd2, 6'd5,  32'd4},          // R3 and
    {8'd3,  2'd2, 6'd7,  32'd13},         // R3 or
    {8'd4,  2'd2, 6'd8,  32'd1},          // R4 signed less
    {8'd4,  2'd2, 6'd9,  32'd0},          // R4 not less
    {8'd6,  2'd1, 6'd3,  32'd2},          // R6 store r3
    {8'd8,  2'd2, 6'd0,  32'd0},          // R8 r0 unwritten
    {8'd8,  2'd1, 6'd4,  32'd0},          // R8 stored r0 reads 0
    {8'd7,  2'd2, 6'd10, 32'd0},          // R7 skipped writers
    {8'd9,  2'd2, 6'd11, 32'd0},          // R9 undefined no write
    {8'd5,  2'd2, 6'd12, 32'hFFFFFFFD},   // R5 negative offset
    {8'd6,  2'd1, 6'd5,  32'd13},         // R6 store with base
    {8'd6,  2'd1, 6'd0,  32'd5},          // R6 other word untouched
    {8'd10, 2'd0, 6'd13, 32'h10210002},   // R10 imem readback
    {8'd9,  2'd1, 6'd6,  32'd0}           // R9 undefined no store
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic progWord(input logic sel, input int idx, input logic [31:0] val);
    @(negedge clk);
    progWe = 1'b1; progSel = sel; progAddr = AW'(idx); progData = val;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    // preload under reset (R1, R10)
    for (int i = 0; i < 64; i++)
      progWord(1'b0, i, (i < NPROG) ? PROG[i] : 32'd0);
    for (int i = 0; i < 64; i++) begin
      logic [31:0] d;
      case (i)
        0: d = 32'd5;
        1: d = 32'hFFFFFFFD;
        2: d = 32'd12;
        3: d = 32'h11111111;
        4: d = 32'h0000DEAD;
        5: d = 32'h0000AAAA;
        default: d = 32'd0;
      endcase
      progWord(1'b1, i, d);
    end
    @(negedge clk);
    check(1, pc, 32'd0);              // R1 PC zero during reset
    dbgSel = 2'd2; dbgAddr = 6'd1; #1;
    check(1, dbgData, 32'd0);         // R1 registers cleared
    dbgSel = 2'd1; dbgAddr = 6'd4; #1;
    check(10, dbgData, 32'h0000DEAD); // R10 data readback

    rst = 1'b0;
    @(negedge clk);
    check(2, pc, 32'd4);              // R2 one instruction per edge
    @(negedge clk);
    check(2, pc, 32'd8);              // R2
    repeat (30) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      dbgSel  = VEC[v][39:38];
      dbgAddr = VEC[v][37:32];
      #1;
      check(int'(VEC[v][47:40]), dbgData, VEC[v][31:0]);
    end

    check(7, pc, 32'd76);             // R7 backward self-loop target
    @(negedge clk);
    check(7, pc, 32'd76);             // R7 loop holds

    rst = 1'b1;                       // R1 reset mid-run
    @(negedge clk);
    check(1, pc, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(2, pc, 32'd4);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule